// File: doc/BRIEF.md
# Two-Channel Triggered Capture Buffer

This block records pairs of 14-bit ADC samples into an on-chip readout memory of 32-bit words. Every clock it takes one sample from each of two channels, called m and n. Each sample carries an out-of-range flag. The pair passes through a programmable delay line. Capture begins either on an external trigger pulse or on a self-trigger. The self-trigger fires when the delayed channel-n sample reaches a programmable threshold. Each trigger stores a programmed number of consecutive words. The total fill is bounded by a buffer-size setting.

Stored words are packed so that software can read both channels from a single word. The memory can only be read from the bus side, through a synchronous read port. Clearing the trigger-active control rewinds the buffer for the next acquisition. One clock period is one 8 ns delay step.

Top module: `adc_capture_buf`

## Requirements
- R1: A stored word holds channel-n data in bits [29:16] and the channel-n out-of-range flag in bit 30. It holds channel-m data in bits [13:0] and the channel-m out-of-range flag in bit 14. Bits 31 and 15 are zero.
- R2: The word written at a clock edge is the sample pair that was present at the edge `delay_i`+1 edges earlier. With `delay_i`=0 this is the pair from the previous edge.
- R3: While the block is idle, armed and not full, `ext_trig_i` high at an edge writes the first word of a capture at that same edge.
- R4: The self-trigger fires when the delayed channel-n data, zero-extended to 16 bits, is greater than or equal to `threshold_i`. A threshold of 0xFFFF disables it.
- R5: Each trigger writes `samples_i` words at consecutive addresses on consecutive edges. A value of 0 writes nothing. `wr_count_o` grows by at most one per edge.
- R6: Any trigger that arrives while `busy_o` is high is ignored. `busy_o` falls after the last write of a capture, and the next edge can start a new capture.
- R7: The fill limit is the smaller of `buf_size_i` and DEPTH. `full_o` is high when `wr_count_o` has reached the limit. While full, no word is written and `wr_count_o` holds.
- R8: While `trig_active_i` is low, no word is written. An edge with `trig_active_i` low sets `wr_count_o` to 0 and `busy_o` to 0.
- R9: `rd_data_o` shows the word at `rd_addr_i` one edge after the address is presented. If that word is written at the same edge, the read returns the old contents.
- R10: After reset, `wr_count_o` and `rd_data_o` are 0, `busy_o` is 0, and the delay line holds zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, one sample pair per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_active_i | input | 1 | Arms capture; low rewinds the buffer |
| ext_trig_i | input | 1 | External trigger, level sampled each edge |
| ch_m_dat_i | input | 14 | Channel m sample |
| ch_m_ovr_i | input | 1 | Channel m out-of-range flag |
| ch_n_dat_i | input | 14 | Channel n sample (monitored by self-trigger) |
| ch_n_ovr_i | input | 1 | Channel n out-of-range flag |
| delay_i | input | 6 | Input delay in clock cycles |
| samples_i | input | 8 | Words stored per trigger |
| threshold_i | input | 16 | Self-trigger threshold, 0xFFFF disables |
| buf_size_i | input | 13 | Fill limit in words |
| rd_addr_i | input | 10 | Read address |
| rd_data_o | output | 32 | Read data, one cycle latency |
| wr_count_o | output | 13 | Words stored since rewind |
| busy_o | output | 1 | Capture in progress |
| full_o | output | 1 | Fill limit reached |

## Verification
A wrong fill pointer or a wrong count of remaining samples shows at `wr_count_o` on the very next edge. The same is true of a missed re-arm, since `busy_o` and the count then diverge from a reference within one cycle. A wrong delay tap, a swapped packing field or a misplaced write address cannot be seen until the word is read back. The bench therefore reads back every written location, and such a fault surfaces one cycle after the address is presented. The threshold comparison shows as a capture that starts one edge early or late, and the count exposes that immediately.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int SMP_W = 14;

  typedef struct packed {
    logic             ovr_n;
    logic [SMP_W-1:0] dat_n;
    logic             ovr_m;
    logic [SMP_W-1:0] dat_m;
  } pair_t;

  localparam int PAIR_W = $bits(pair_t);

  function automatic logic [31:0] pack_word(pair_t p);
    return {1'b0, p.ovr_n, p.dat_n, 1'b0, p.ovr_m, p.dat_m};
  endfunction
endpackage

// File: rtl/adc_cap_delay.sv
module adc_cap_delay
  import adc_cap_pkg::*;
#(
  parameter int DLY_W = 6,
  localparam int TAPS = 1 << DLY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pair_t            pair_i,
  input  logic [DLY_W-1:0] delay_i,
  output pair_t            pair_o
);
  pair_t sr_q [TAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TAPS; i++) sr_q[i] <= '0;
    end else begin
      sr_q[0] <= pair_i;
      for (int i = 1; i < TAPS; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign pair_o = sr_q[delay_i];
endmodule

// File: rtl/adc_cap_thresh.sv
module adc_cap_thresh #(
  parameter int DAT_W = 14,
  parameter int THR_W = 16
) (
  input  logic [DAT_W-1:0] dat_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             hit_o
);
  logic off;
  assign off   = &thr_i;
  assign hit_o = !off && (THR_W'(dat_i) >= thr_i);
endmodule

// File: rtl/adc_cap_seq.sv
module adc_cap_seq #(
  parameter int DEPTH  = 1024,
  parameter int SIZE_W = 13,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              ext_i,
  input  logic              self_i,
  input  logic [CNT_W-1:0]  samples_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              we_o,
  output logic [SIZE_W-1:0] wptr_o,
  output logic              busy_o,
  output logic              full_o
);
  logic [SIZE_W-1:0] wptr_q, wptr_nxt, lim;
  logic [CNT_W-1:0]  rem_q;
  logic              busy_q, start;

  assign lim      = (size_i > SIZE_W'(DEPTH)) ? SIZE_W'(DEPTH) : size_i;
  assign full_o   = wptr_q >= lim;
  assign wptr_nxt = wptr_q + 1'b1;
  assign start    = active_i && !busy_q && !full_o && (ext_i || self_i) && (samples_i != '0);
  assign we_o     = active_i && !full_o && (start || busy_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rem_q  <= '0;
      busy_q <= 1'b0;
    end else if (!active_i) begin
      wptr_q <= '0;
      rem_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      wptr_q <= wptr_nxt;
      rem_q  <= samples_i - 1'b1;
      busy_q <= (samples_i > CNT_W'(1)) && (wptr_nxt < lim);
    end else if (busy_q) begin
      if (full_o) begin
        busy_q <= 1'b0;
      end else begin
        wptr_q <= wptr_nxt;
        rem_q  <= rem_q - 1'b1;
        busy_q <= (rem_q != CNT_W'(1)) && (wptr_nxt < lim);
      end
    end
  end

  assign wptr_o = wptr_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/adc_cap_ram.sv
module adc_cap_ram #(
  parameter int DEPTH  = 1024,
  parameter int WORD_W = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (int'(raddr_i) < DEPTH) rdata_o <= mem_q[raddr_i];
    else rdata_o <= '0;
  end
endmodule

// File: rtl/adc_capture_buf.sv
module adc_capture_buf
  import adc_cap_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int SIZE_W = 13,
  parameter int CNT_W  = 8,
  parameter int DLY_W  = 6,
  parameter int THR_W  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_active_i,
  input  logic              ext_trig_i,
  input  logic [SMP_W-1:0]  ch_m_dat_i,
  input  logic              ch_m_ovr_i,
  input  logic [SMP_W-1:0]  ch_n_dat_i,
  input  logic              ch_n_ovr_i,
  input  logic [DLY_W-1:0]  delay_i,
  input  logic [CNT_W-1:0]  samples_i,
  input  logic [THR_W-1:0]  threshold_i,
  input  logic [SIZE_W-1:0] buf_size_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic [SIZE_W-1:0] wr_count_o,
  output logic              busy_o,
  output logic              full_o
);
  pair_t             in_pair, dly_pair;
  logic              self_hit, we;
  logic [SIZE_W-1:0] wptr;

  assign in_pair = '{ovr_n: ch_n_ovr_i, dat_n: ch_n_dat_i,
                     ovr_m: ch_m_ovr_i, dat_m: ch_m_dat_i};

  adc_cap_delay #(.DLY_W(DLY_W)) i_delay (
    .clk_i, .rst_ni, .pair_i(in_pair), .delay_i, .pair_o(dly_pair)
  );

  adc_cap_thresh #(.DAT_W(SMP_W), .THR_W(THR_W)) i_thresh (
    .dat_i(dly_pair.dat_n), .thr_i(threshold_i), .hit_o(self_hit)
  );

  adc_cap_seq #(.DEPTH(DEPTH), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) i_seq (
    .clk_i, .rst_ni, .active_i(trig_active_i), .ext_i(ext_trig_i),
    .self_i(self_hit), .samples_i, .size_i(buf_size_i),
    .we_o(we), .wptr_o(wptr), .busy_o, .full_o
  );

  adc_cap_ram #(.DEPTH(DEPTH), .WORD_W(32)) i_ram (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(wptr[ADDR_W-1:0]),
    .wdata_i(pack_word(dly_pair)), .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );

  assign wr_count_o = wptr;
endmodule

// File: rtl/adc_capture_buf_chk.sv
module adc_capture_buf_chk #(
  parameter int DEPTH  = 1024,
  parameter int SIZE_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trig_active_i,
  input logic [SIZE_W-1:0] wr_count_o,
  input logic              busy_o,
  input logic              full_o
);
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(wr_count_o) <= DEPTH); // R7

  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && trig_active_i |=> $stable(wr_count_o)); // R7

  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_active_i |=> (wr_count_o == '0) && !busy_o); // R8

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_active_i |=> (wr_count_o == $past(wr_count_o)) ||
                      (wr_count_o == $past(wr_count_o) + 1'b1)); // R5
endmodule

bind adc_capture_buf adc_capture_buf_chk #(.DEPTH(DEPTH), .SIZE_W(SIZE_W)) i_chk (.*);

// File: tb/test_adc_capture_buf.sv
module test_adc_capture_buf;
  localparam int DEPTH = 1024;

  logic        clk = 0, rst_n = 0;
  logic        act = 0, ext = 0, n_high = 0;
  logic [13:0] m_dat = 0, n_dat = 0;
  logic        m_ovr = 0, n_ovr = 0;
  logic [5:0]  dly = 0;
  logic [7:0]  smp = 4;
  logic [15:0] thr = 16'hFFFF;
  logic [12:0] bsz = 13'd5120;
  logic [9:0]  raddr = 0;
  logic [31:0] rdata;
  logic [12:0] wcnt;
  logic        busy, full;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_capture_buf i_adc_capture_buf (
    .clk_i(clk), .rst_ni(rst_n), .trig_active_i(act), .ext_trig_i(ext),
    .ch_m_dat_i(m_dat), .ch_m_ovr_i(m_ovr), .ch_n_dat_i(n_dat), .ch_n_ovr_i(n_ovr),
    .delay_i(dly), .samples_i(smp), .threshold_i(thr), .buf_size_i(bsz),
    .rd_addr_i(raddr), .rd_data_o(rdata), .wr_count_o(wcnt),
    .busy_o(busy), .full_o(full)
  );

  // free-running sample source
  always @(negedge clk) begin
    #1;
    cyc++;
    m_dat = 14'(cyc * 37);
    m_ovr = cyc[2];
    n_ovr = cyc[3];
    n_dat = n_high ? 14'h1000 + 14'(cyc[3:0]) : 14'(cyc * 13) & 14'h07FF;
  end

  // reference model
  logic [31:0] hist[$];
  logic [31:0] mem_m [DEPTH];
  bit          ok_m [DEPTH];
  int          cnt_m, rem_m;
  bit          busy_m, rd_ok;
  logic [31:0] rd_exp;

  function automatic int lim_f();
    return (int'(bsz) > DEPTH) ? DEPTH : int'(bsz);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {};
      for (int i = 0; i < 64; i++) hist.push_back('0);
      cnt_m = 0; rem_m = 0; busy_m = 0; rd_exp = '0; rd_ok = 1;
      for (int i = 0; i < DEPTH; i++) ok_m[i] = 0;
    end else begin
      logic [31:0] cur;
      bit wr, hit;
      cur = hist[dly];
      rd_ok = ok_m[raddr];
      rd_exp = mem_m[raddr];
      hit = (thr != 16'hFFFF) && (int'(cur[29:16]) >= int'(thr));
      wr = 0;
      if (!act) begin
        cnt_m = 0; busy_m = 0;
      end else if (cnt_m >= lim_f()) begin
        busy_m = 0;
      end else if (busy_m) begin
        wr = 1; rem_m--;
      end else if ((ext || hit) && smp != 0) begin
        wr = 1; rem_m = int'(smp) - 1;
      end
      if (wr) begin
        mem_m[cnt_m] = cur; ok_m[cnt_m] = 1; cnt_m++;
        busy_m = (rem_m > 0) && (cnt_m < lim_f());
      end
      hist.push_front({1'b0, n_ovr, n_dat, 1'b0, m_ovr, m_dat});
      void'(hist.pop_back());
    end
  end

  task automatic check(bit ok, string req, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act_v, exp_v, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(wcnt) == cnt_m, "R5 wr_count", int'(wcnt), cnt_m);
      check(full == (cnt_m >= lim_f()), "R7 full", int'(full), int'(cnt_m >= lim_f()));
      check(busy == busy_m, "R6 busy", int'(busy), int'(busy_m));
      if (rd_ok)
        check(rdata == rd_exp, "R1 R2 R3 R4 R9 readback", int'(rdata), int'(rd_exp));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic pulse();
    @(negedge clk); #2 ext = 1;
    @(negedge clk); #2 ext = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R10 reset state
    check(wcnt == 0 && !busy, "R10 reset count/busy", int'(wcnt), 0);
    check(rdata == 0, "R10 reset rd_data", int'(rdata), 0);
    rst_n = 1;
    tick(2);
    // R8 trigger ignored while inactive
    pulse(); tick(3);
    check(wcnt == 0, "R8 inactive no write", int'(wcnt), 0);
    // R3 R5 external trigger, 4 samples, no delay
    act = 1; tick(2);
    pulse(); tick(8);
    check(wcnt == 4, "R3 R5 four words", int'(wcnt), 4);
    // R2 delay 5
    dly = 6'd5; tick(8);
    pulse(); tick(8);
    check(wcnt == 8, "R2 delayed capture", int'(wcnt), 8);
    // R6 trigger during capture ignored
    smp = 8'd10;
    pulse(); tick(2); pulse(); tick(15);
    check(wcnt == 18, "R6 retrigger ignored", int'(wcnt), 18);
    // R5 zero samples
    smp = 8'd0;
    pulse(); tick(4);
    check(wcnt == 18, "R5 zero samples", int'(wcnt), 18);
    // R4 self-trigger disabled then enabled
    smp = 8'd3; dly = 6'd2;
    n_high = 1; tick(10);
    check(wcnt == 18, "R4 threshold FFFF disables", int'(wcnt), 18);
    thr = 16'h1008; tick(12);
    n_high = 0; tick(70);
    check(wcnt > 18, "R4 self-trigger fired", int'(wcnt), 19);
    // R7 buffer limit, R8 rewind
    act = 0; tick(2);
    check(wcnt == 0, "R8 rewind", int'(wcnt), 0);
    act = 1; thr = 16'hFFFF; bsz = 13'd20; smp = 8'd8;
    for (int k = 0; k < 4; k++) begin pulse(); tick(12); end
    check(wcnt == 20 && full, "R7 limit 20", int'(wcnt), 20);
    // R7 limit capped at DEPTH
    bsz = 13'd5120; smp = 8'd255; dly = 6'd63;
    for (int k = 0; k < 6; k++) begin pulse(); tick(270); end
    check(wcnt == 13'(DEPTH) && full, "R7 depth cap", int'(wcnt), DEPTH);
    // R9 read back every location
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk); #2 raddr = 10'(a);
    end
    tick(3);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule